// File: doc/BRIEF.md
# Multiplexed 16-bit Bus Host Initiator

This block is the host end of a narrow bus on which address and data share one 16-bit path. A local agent hands it one request at a time: a 32-bit address, a direction, an access size of one, two or four bytes, and write data. The initiator opens a frame, signals the direction on its two byte strobes, sends the address as two half-words, and then moves data in one or two beats. Each beat waits for a ready strobe from the target.

Read data comes back on `rd_data`, together with a one-cycle `done` pulse. If the target never selects itself after the address, the initiator gives up after a set number of clocks. It returns to idle and raises `done` with `done_err`. All bus strobes are active low. The shared path is split into a driven half (`bus_ad_out` with `bus_ad_oe`) and a sampled half (`bus_ad_in`), so the pad ring can build the tristate.

Top module: `mbus_initiator`

## Requirements
- R1: A request is taken only in a cycle where `req_ready` is high, which is only when idle. `req_valid` raised while a transfer is running has no effect on the bus lines or on the number of `done` pulses.
- R2: In the cycle after a request is taken, `bus_frame_n` is 0 and `bus_hi_n` is 1. `bus_lo_n` gives the direction: 1 for a read, 0 for a write. `bus_ad_out` carries address bits 15:0 with `bus_ad_oe` = 1.
- R3: In the next cycle both strobes are 0 and `bus_ad_out` carries address bits 31:16, still driven.
- R4: During the data beats, `req_size` 0 (byte) gives `bus_lo_n` = 0 with `bus_hi_n` = 1. Sizes 1 (half-word), 2 and 3 (both word) give both strobes at 0.
- R5: On a write, the data beats drive `bus_ad_out` with `bus_ad_oe` = 1. A byte write puts the byte in bits 7:0 with bits 15:8 zero. A half-word write sends bits 15:0. A word write sends bits 15:0 on the first beat and bits 31:16 on the second.
- R6: On a read, `bus_ad_oe` is 0 during the data beats, and `bus_ad_in` is captured on each cycle where `bus_ready_n` is sampled low. `rd_data` is zero-extended for byte (bits 7:0) and half-word reads. For a word read it is {second beat, first beat}.
- R7: `done` is high for exactly one cycle: the cycle after the final `bus_ready_n` low sample. In that cycle `bus_frame_n` is back at 1, `req_ready` is 1, and `rd_data` is valid.
- R8: On a word access, `bus_frame_n` goes to 1 in the cycle after the first ready sample. The transfer completes only on a second ready sample.
- R9: If `bus_sel_n` stays high for `TMO_CYCLES` consecutive data-phase cycles, the transfer ends: `done` and `done_err` rise together in the next cycle, and the block is idle. Once `bus_sel_n` has been seen low in a transfer, no timeout occurs, however long ready takes.
- R10: `done_err` is 0 on every `done` that ends with a ready strobe.
- R11: After reset: `bus_frame_n`, `bus_lo_n` and `bus_hi_n` are 1, `bus_ad_oe` is 0, `done` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Initiator idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_addr | input | 32 | Transfer address |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a select timeout |
| rd_data | output | 32 | Read result, valid with done |
| bus_frame_n | output | 1 | Frame request, active low |
| bus_lo_n | output | 1 | Low byte strobe, active low |
| bus_hi_n | output | 1 | High byte strobe, active low |
| bus_ad_out | output | 16 | Address/data driven value |
| bus_ad_oe | output | 1 | Drive enable for the address/data path |
| bus_ad_in | input | 16 | Address/data sampled value |
| bus_ready_n | input | 1 | Target ready strobe, active low |
| bus_sel_n | input | 1 | Target select, active low |

## Verification
All bus outputs are decoded from state, so the timing follows from the request being taken at edge 0. The low-address frame is visible after edge 0, the high address after edge 1, and the first data beat after edge 2. `done` and `rd_data` are due one cycle after the edge that samples the final ready strobe. For a word access, the frame release is due one cycle after the first ready sample, and a timeout completion is due exactly `TMO_CYCLES` cycles after the first data-phase cycle. The bench drives and samples on the falling edge. It walks each transfer one cycle at a time against these counts, so every check lands in the one cycle where its result is due.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam int AD_W   = 16;
  localparam int ADDR_W = 2 * AD_W;
  localparam int SZ_W   = 2;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ADDR_LO = 2'd1,
    ST_ADDR_HI = 2'd2,
    ST_DATA    = 2'd3
  } mbus_state_t;

  function automatic logic sz_is_byte(input logic [SZ_W-1:0] sz);
    return sz == 2'b00;
  endfunction

  function automatic logic sz_is_word(input logic [SZ_W-1:0] sz);
    return sz[1];
  endfunction

  // Strobes in a data beat, packed {lo_n, hi_n}
  function automatic logic [1:0] data_strobes(input logic [SZ_W-1:0] sz);
    return sz_is_byte(sz) ? 2'b01 : 2'b00;
  endfunction

  // Strobes on the frame-start cycle, packed {lo_n, hi_n}
  function automatic logic [1:0] start_strobes(input logic wr);
    return {~wr, 1'b1};
  endfunction

  function automatic logic [AD_W-1:0] write_half(input logic [SZ_W-1:0] sz,
                                                 input logic [ADDR_W-1:0] wd,
                                                 input logic ph);
    logic [AD_W-1:0] h;
    if (sz_is_byte(sz))          h = {{(AD_W/2){1'b0}}, wd[AD_W/2-1:0]};
    else if (sz_is_word(sz) && ph) h = wd[ADDR_W-1:AD_W];
    else                         h = wd[AD_W-1:0];
    return h;
  endfunction

  function automatic logic [ADDR_W-1:0] read_merge(input logic [SZ_W-1:0] sz,
                                                   input logic [AD_W-1:0] lo,
                                                   input logic [AD_W-1:0] hi);
    logic [ADDR_W-1:0] r;
    if (sz_is_byte(sz))      r = {{(ADDR_W-AD_W/2){1'b0}}, lo[AD_W/2-1:0]};
    else if (sz_is_word(sz)) r = {hi, lo};
    else                     r = {{(ADDR_W-AD_W){1'b0}}, lo};
    return r;
  endfunction

endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              ready_n,
  input  logic              abort,
  output logic              req_ready,
  output logic              start_evt,
  output logic              beat_evt,
  output logic              last_beat,
  output mbus_state_t       state,
  output logic              phase,
  output logic              write_q,
  output logic [SZ_W-1:0]   size_q,
  output logic              frame_n,
  output logic              lo_n,
  output logic              hi_n,
  output logic              done,
  output logic              done_err
);

  mbus_state_t state_nx;
  logic        finish_evt;
  logic        word_mid;

  assign req_ready  = (state == ST_IDLE);
  assign start_evt  = req_valid && req_ready;
  assign beat_evt   = (state == ST_DATA) && !ready_n;
  assign last_beat  = beat_evt && (!sz_is_word(size_q) || phase);
  assign word_mid   = beat_evt && sz_is_word(size_q) && !phase;
  assign finish_evt = last_beat || abort;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (start_evt) state_nx = ST_ADDR_LO;
      ST_ADDR_LO: state_nx = ST_ADDR_HI;
      ST_ADDR_HI: state_nx = ST_DATA;
      ST_DATA:    if (finish_evt) state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      write_q  <= 1'b0;
      size_q   <= '0;
      done     <= 1'b0;
      done_err <= 1'b0;
    end else begin
      state    <= state_nx;
      done     <= finish_evt;
      done_err <= abort;
      if (start_evt) begin
        write_q <= req_write;
        size_q  <= req_size;
        phase   <= 1'b0;
      end else if (word_mid && !abort) begin
        phase <= 1'b1;
      end
    end
  end

  // Bus strobes decoded from state
  always_comb begin
    frame_n    = 1'b1;
    {lo_n, hi_n} = 2'b11;
    unique case (state)
      ST_IDLE: ;
      ST_ADDR_LO: begin
        frame_n      = 1'b0;
        {lo_n, hi_n} = start_strobes(write_q);
      end
      ST_ADDR_HI: begin
        frame_n      = 1'b0;
        {lo_n, hi_n} = 2'b00;
      end
      ST_DATA: begin
        frame_n      = phase;
        {lo_n, hi_n} = data_strobes(size_q);
      end
      default: ;
    endcase
  end

  assert_accept_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_LO) |-> $past(state == ST_IDLE));

  assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!frame_n && hi_n && (lo_n == !$past(req_write))));

  assert_addr_hi_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_LO) |=> (!lo_n && !hi_n && !frame_n));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_word_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_mid && !abort) |=> (frame_n && !done));

endmodule

// File: rtl/mbus_timeout.sv
module mbus_timeout #(
  parameter int TMO_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_data,
  input  logic sel_n,
  output logic abort
);

  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          sel_seen;
  logic          waiting;

  assign waiting = in_data && !sel_seen && sel_n;
  assign abort   = waiting && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sel_seen <= 1'b0;
    end else if (!in_data) begin
      cnt      <= '0;
      sel_seen <= 1'b0;
    end else begin
      if (!sel_n) sel_seen <= 1'b1;
      if (waiting && !abort) cnt <= cnt + 1'b1;
    end
  end

  assert_no_abort_after_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !sel_n) |=> !abort);

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_wdata,
  input  mbus_state_t       state,
  input  logic              phase,
  input  logic              write_q,
  input  logic [SZ_W-1:0]   size_q,
  input  logic              beat_evt,
  input  logic              last_beat,
  input  logic [AD_W-1:0]   ad_in,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wdata_q;
  logic [AD_W-1:0]   lo_q;
  logic              rd_beat;

  assign rd_beat = beat_evt && !write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      lo_q    <= '0;
      rd_data <= '0;
    end else begin
      if (start_evt) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_beat) begin
        if (last_beat) rd_data <= read_merge(size_q, phase ? lo_q : ad_in, ad_in);
        else           lo_q    <= ad_in;
      end
    end
  end

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    unique case (state)
      ST_IDLE: ;
      ST_ADDR_LO: begin
        ad_out = addr_q[AD_W-1:0];
        ad_oe  = 1'b1;
      end
      ST_ADDR_HI: begin
        ad_out = addr_q[ADDR_W-1:AD_W];
        ad_oe  = 1'b1;
      end
      ST_DATA: begin
        ad_oe  = write_q;
        ad_out = write_q ? write_half(size_q, wdata_q, phase) : '0;
      end
      default: ;
    endcase
  end

  assert_addr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_LO) |=> (ad_oe && ad_out == $past(addr_q[ADDR_W-1:AD_W])));

  assert_read_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !write_q) |-> !ad_oe);

endmodule

// File: rtl/mbus_initiator.sv
module mbus_initiator
  import mbus_pkg::*;
#(
  parameter int TMO_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        done,
  output logic        done_err,
  output logic [31:0] rd_data,
  output logic        bus_frame_n,
  output logic        bus_lo_n,
  output logic        bus_hi_n,
  output logic [15:0] bus_ad_out,
  output logic        bus_ad_oe,
  input  logic [15:0] bus_ad_in,
  input  logic        bus_ready_n,
  input  logic        bus_sel_n
);

  mbus_state_t     state;
  logic            start_evt;
  logic            beat_evt;
  logic            last_beat;
  logic            phase;
  logic            write_q;
  logic [SZ_W-1:0] size_q;
  logic            abort;

  mbus_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .ready_n   (bus_ready_n),
    .abort     (abort),
    .req_ready (req_ready),
    .start_evt (start_evt),
    .beat_evt  (beat_evt),
    .last_beat (last_beat),
    .state     (state),
    .phase     (phase),
    .write_q   (write_q),
    .size_q    (size_q),
    .frame_n   (bus_frame_n),
    .lo_n      (bus_lo_n),
    .hi_n      (bus_hi_n),
    .done      (done),
    .done_err  (done_err)
  );

  mbus_timeout #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_data (state == ST_DATA),
    .sel_n   (bus_sel_n),
    .abort   (abort)
  );

  mbus_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .state     (state),
    .phase     (phase),
    .write_q   (write_q),
    .size_q    (size_q),
    .beat_evt  (beat_evt),
    .last_beat (last_beat),
    .ad_in     (bus_ad_in),
    .ad_out    (bus_ad_out),
    .ad_oe     (bus_ad_oe),
    .rd_data   (rd_data)
  );

  assert_timeout_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (done && done_err && req_ready));

  assert_clean_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !abort) |=> (done && !done_err));

endmodule

// File: tb/mbus_initiator_tb.sv
module mbus_initiator_tb;

  localparam int TMO = 12;
  localparam int NV  = 8;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] rv;
    logic [7:0]  dly;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 32'h0060_1234, 32'hFFFF_FF57, 32'h0,           8'd0},
    '{1'b0, 2'd0, 32'h0060_1234, 32'h0,         32'h0000_0057,  8'd1},
    '{1'b1, 2'd1, 32'hA0B0_0042, 32'h1234_3975, 32'h0,           8'd2},
    '{1'b0, 2'd1, 32'hA0B0_0042, 32'h0,         32'h0000_3975,  8'd0},
    '{1'b1, 2'd2, 32'h0060_0400, 32'hDEAD_C0DE, 32'h0,           8'd1},
    '{1'b0, 2'd2, 32'h0060_0400, 32'h0,         32'hDEAD_C0DE,  8'd3},
    '{1'b0, 2'd2, 32'hFFFF_FFFC, 32'h0,         32'h8001_7FFE,  8'd20},
    '{1'b1, 2'd3, 32'h0000_0000, 32'h0102_0304, 32'h0,           8'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic        done_err;
  logic [31:0] rd_data;
  logic        bus_frame_n;
  logic        bus_lo_n;
  logic        bus_hi_n;
  logic [15:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [15:0] bus_ad_in = '0;
  logic        bus_ready_n = 1'b1;
  logic        bus_sel_n = 1'b1;

  int total = 0;
  int fails = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  mbus_initiator #(.TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .done_err(done_err), .rd_data(rd_data),
    .bus_frame_n(bus_frame_n), .bus_lo_n(bus_lo_n), .bus_hi_n(bus_hi_n),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_ready_n(bus_ready_n), .bus_sel_n(bus_sel_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_wr_half(input vec_t v, input bit second);
    if (v.sz == 2'd0) return v.wd & 32'h0000_00FF;
    if (v.sz[1] && second) return v.wd >> 16;
    return v.wd & 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] exp_rd(input vec_t v);
    if (v.sz == 2'd0) return v.rv & 32'h0000_00FF;
    if (v.sz == 2'd1) return v.rv & 32'h0000_FFFF;
    return v.rv;
  endfunction

  task automatic pulse_ready(input int dly, input logic [15:0] val);
    repeat (dly) @(negedge clk);
    bus_ready_n = 1'b0;
    bus_ad_in   = val;
    @(negedge clk);
    bus_ready_n = 1'b1;
    bus_ad_in   = 16'h5A5A;
  endtask

  task automatic run_vec(input vec_t v);
    bit word = v.sz[1];
    @(negedge clk);
    chk("R1 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = v.wr; req_size = v.sz;
    req_addr = v.addr; req_wdata = v.wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 frame low", {31'd0, bus_frame_n}, 32'd0);
    chk("R2 strobes {lo,hi}", {30'd0, bus_lo_n, bus_hi_n}, {30'd0, ~v.wr, 1'b1});
    chk("R2 address low half", {15'd0, bus_ad_oe, bus_ad_out}, {15'd0, 1'b1, v.addr[15:0]});
    @(negedge clk);
    chk("R3 strobes {lo,hi}", {30'd0, bus_lo_n, bus_hi_n}, 32'd0);
    chk("R3 address high half", {15'd0, bus_ad_oe, bus_ad_out}, {15'd0, 1'b1, v.addr[31:16]});
    @(negedge clk);
    bus_sel_n = 1'b0;
    chk("R4 data strobes", {30'd0, bus_lo_n, bus_hi_n}, (v.sz == 2'd0) ? 32'd1 : 32'd0);
    if (v.wr) chk("R5 write beat one", {15'd0, bus_ad_oe, bus_ad_out}, {15'd0, 1'b1, exp_wr_half(v, 1'b0)});
    else      chk("R6 read releases AD", {31'd0, bus_ad_oe}, 32'd0);
    pulse_ready(v.dly, (v.sz == 2'd0) ? {8'hA5, v.rv[7:0]} : v.rv[15:0]);
    if (word) begin
      chk("R8 frame released mid word", {30'd0, bus_frame_n, done}, 32'd2);
      chk("R4 word second beat strobes", {30'd0, bus_lo_n, bus_hi_n}, 32'd0);
      if (v.wr) chk("R5 write beat two", {15'd0, bus_ad_oe, bus_ad_out}, {15'd0, 1'b1, exp_wr_half(v, 1'b1)});
      pulse_ready(v.dly, v.rv[31:16]);
    end
    chk("R7 done with frame high and ready", {29'd0, done, bus_frame_n, req_ready}, 32'd7);
    chk("R10 no error", {31'd0, done_err}, 32'd0);
    if (!v.wr) chk("R6 read data", rd_data, exp_rd(v));
    bus_sel_n = 1'b1;
    @(negedge clk);
    chk("R7 done single cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R11 reset strobes", {29'd0, bus_frame_n, bus_lo_n, bus_hi_n}, 32'd7);
    chk("R11 reset oe/done/ready", {29'd0, bus_ad_oe, done, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: request held while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd1;
    req_addr = 32'h1357_2468; req_wdata = '0;
    @(negedge clk);
    req_addr = 32'h1111_2222; req_write = 1'b1;
    chk("R1 busy ready low", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R1 busy address unchanged", {16'd0, bus_ad_out}, 32'h1357);
    @(negedge clk);
    bus_sel_n = 1'b0;
    chk("R1 busy direction unchanged", {31'd0, bus_ad_oe}, 32'd0);
    req_valid = 1'b0;
    pulse_ready(0, 16'hBEEF);
    chk("R1 busy transfer done", {31'd0, done}, 32'd1);
    bus_sel_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1 no second transfer", {30'd0, bus_frame_n, done}, 32'd2);
    end

    // R9: select never arrives
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd1;
    req_addr = 32'h00AA_0010; req_wdata = 32'h0000_1234;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 1; k < TMO; k++) begin
      @(negedge clk);
      chk("R9 no early timeout", {31'd0, done}, 32'd0);
    end
    @(negedge clk);
    chk("R9 timeout done and err", {30'd0, done, done_err}, 32'd3);
    chk("R9 idle after timeout", {30'd0, bus_frame_n, req_ready}, 32'd3);
    @(negedge clk);
    chk("R9 error pulse ends", {30'd0, done, done_err}, 32'd0);

    // After a timeout a normal transfer completes without error
    run_vec(VECS[3]);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule